// File: doc/BRIEF.md
# NAND Sector ECC Syndrome Checker and Corrector

This block compares, sector by sector, the 24-bit Hamming code read back from a flash page's spare area with the 24-bit code computed over the data just received. Each code is first rearranged into parity-pair order. The two are then XORed into a syndrome. The number of set bits in the syndrome sets the outcome: clean, one data bit that can be corrected, or a failure that cannot. A correctable error also yields the byte offset inside the 512-byte sector and the bit index to flip.

A page has either one sector or four. The caller pulses `start` with every code slice of the page. The block emits one result per cycle, in sector order, and stops at the first sector that cannot be corrected. A blank page is accepted as clean: its stored code is all ones and the computed code is all zeros. Each correction found is kept per sector. A patch port XORs the matching bit into any byte that the caller passes through with its page address. This lets a page buffer be fixed on the way out, without storage inside this block.

Control is a two-state machine. `S_IDLE` waits. The transition `GO` (start seen in `S_IDLE`) latches the codes and the mode and moves to `S_SCAN`. `S_SCAN` judges one sector per cycle. It takes `NEXT` (stay in `S_SCAN`, advance the sector) while sectors remain and the current one is not fatal. It takes `STOP` (back to `S_IDLE`) on the last sector or on a fatal one.

Top module: `nand_ecc_corrector`

## Requirements
- R1: When the stored and computed codes of a sector are equal, its result has status 2'b00 (clean) with offset 0 and bit 0.
- R2: Code bit layout: bits 0..7 hold the even parity of pairs P1..P128, bits 8..15 the odd parity of pairs P1..P128, bits 16..19 the even parity of pairs P256..P2048, and bits 20..23 the odd parity of pairs P256..P2048. A syndrome with exactly 12 set bits gives status 2'b01 (corrected). The 9-bit offset is formed from the odd-parity syndrome bits of pairs P2048 down to P8, with P2048 as the MSB. The 3-bit index is formed from the odd-parity bits of P4, P2 and P1, with P4 as the MSB.
- R3: A syndrome with 1 or 11 set bits gives status 2'b10 (uncorrectable).
- R4: Any other nonzero syndrome weight gives 2'b10. The one exception is a stored code of 24'hFFFFFF with a computed code of 24'h000000, which gives 2'b00.
- R5: In four-sector mode (`multi`=1), results come out on consecutive cycles for sectors 0,1,2,3. Sector i uses bits [24i+23:24i] of both code inputs. `res_last` marks sector 3.
- R6: The first uncorrectable sector ends the run. Its result carries `res_last`, and no further result follows.
- R7: In single-sector mode (`multi`=0), only sector 0 is judged and it carries `res_last`. The upper code slices are ignored.
- R8: `patch_out` equals `patch_in` XOR (1 << bit) when `patch_addr` equals sector*512 + offset for a sector corrected in the latest run. Otherwise it equals `patch_in`. A new start clears all stored corrections.
- R9: `busy` rises in the cycle after `start` is accepted. The first result is valid one cycle later. Code and mode inputs are latched at start, and `start` is ignored while `busy`.
- R10: After reset, `res_valid` and `busy` are low and `patch_out` equals `patch_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin checking a page |
| multi | input | 1 | 1: four sectors, 0: one sector |
| stored_code | input | 96 | Codes read from flash, sector i in bits [24i+23:24i] |
| calc_code | input | 96 | Codes computed over received data, same slicing |
| busy | output | 1 | Page check in progress |
| res_valid | output | 1 | Result of one sector is present |
| res_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| res_sector | output | 2 | Sector the result belongs to |
| res_offset | output | 9 | Byte offset of the corrected bit |
| res_bit | output | 3 | Bit index of the corrected bit |
| res_last | output | 1 | Final result of the run |
| patch_addr | input | 11 | Page byte address of the byte being patched |
| patch_in | input | 8 | Byte to be patched |
| patch_out | output | 8 | Byte after correction |

## Verification
The bench builds single-bit data errors from their Hamming signature. A design that took the offset or index from the even-parity bits, or mixed up the code layout, reports the wrong location. Weights 1, 2, 11, 13 and 24 are applied against the weight-12 rule. A design that falls back to "corrected" or to "clean" outside the defined weights is caught, as is one that accepts any all-ones syndrome as a blank page rather than only the exact stored-ones, computed-zeros pair. The multi-sector runs check abort after an uncorrectable sector, patch state that survives a restart, codes that change while the block is busy, and upper slices that leak into single-sector mode.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int PAIRS     = 12;
    localparam int CODE_W    = 2 * PAIRS;
    localparam int LO_PAIRS  = 8;
    localparam int LOC_BIT_W = 3;
    localparam int LOC_OFF_W = PAIRS - LOC_BIT_W;
    localparam int WT_W      = $clog2(CODE_W + 1);

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_FATAL = 2'b10
    } ecc_status_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_SCAN = 1'b1
    } scan_state_e;

    // Reorder a stored-layout code so that pair k sits at bits {2k+1 (odd), 2k (even)}.
    function automatic logic [CODE_W-1:0] pair_order(input logic [CODE_W-1:0] raw);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int k = 0; k < PAIRS; k++) begin
            if (k < LO_PAIRS) begin
                r[2*k]   = raw[k];
                r[2*k+1] = raw[LO_PAIRS + k];
            end else begin
                r[2*k]   = raw[2*LO_PAIRS + (k - LO_PAIRS)];
                r[2*k+1] = raw[2*LO_PAIRS + (PAIRS - LO_PAIRS) + (k - LO_PAIRS)];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_syndrome_unit.sv
module ecc_syndrome_unit
    import nand_ecc_pkg::*;
(
    input  logic [CODE_W-1:0]    stored_i,
    input  logic [CODE_W-1:0]    calc_i,
    output ecc_status_e          status_o,
    output logic [LOC_OFF_W-1:0] off_o,
    output logic [LOC_BIT_W-1:0] bit_o
);

    logic [CODE_W-1:0] syn;
    logic [PAIRS-1:0]  odd_bits;
    logic [WT_W-1:0]   weight;
    logic              blank_page;

    assign syn        = pair_order(stored_i) ^ pair_order(calc_i);
    assign blank_page = (stored_i == '1) && (calc_i == '0);

    always_comb begin
        weight = '0;
        for (int i = 0; i < CODE_W; i++) begin
            weight = weight + WT_W'(syn[i]);
        end
    end

    always_comb begin
        for (int k = 0; k < PAIRS; k++) begin
            odd_bits[k] = syn[2*k+1];
        end
    end

    always_comb begin
        status_o = ST_FATAL;
        off_o    = '0;
        bit_o    = '0;
        if (stored_i == calc_i) begin
            status_o = ST_CLEAN;
        end else begin
            unique case (weight)
                WT_W'(PAIRS): begin
                    status_o = ST_FIXED;
                    off_o    = odd_bits[PAIRS-1:LOC_BIT_W];
                    bit_o    = odd_bits[LOC_BIT_W-1:0];
                end
                WT_W'(1), WT_W'(PAIRS-1): status_o = ST_FATAL;
                default: status_o = blank_page ? ST_CLEAN : ST_FATAL;
            endcase
        end
    end

endmodule

// File: rtl/ecc_fix_store.sv
module ecc_fix_store
    import nand_ecc_pkg::*;
#(
    parameter int SECTORS = 4,
    localparam int SEC_W  = $clog2(SECTORS),
    localparam int ADDR_W = SEC_W + LOC_OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 set_i,
    input  logic [SEC_W-1:0]     set_sec_i,
    input  logic [LOC_OFF_W-1:0] set_off_i,
    input  logic [LOC_BIT_W-1:0] set_bit_i,
    input  logic [ADDR_W-1:0]    patch_addr_i,
    input  logic [7:0]           patch_in_i,
    output logic [7:0]           patch_out_o
);

    logic [SECTORS-1:0]   fix_vld;
    logic [LOC_OFF_W-1:0] fix_off [SECTORS];
    logic [LOC_BIT_W-1:0] fix_bit [SECTORS];
    logic [SECTORS-1:0]   hit;
    logic [SEC_W-1:0]     p_sec;
    logic [LOC_OFF_W-1:0] p_off;

    assign p_sec = patch_addr_i[ADDR_W-1:LOC_OFF_W];
    assign p_off = patch_addr_i[LOC_OFF_W-1:0];

    for (genvar g = 0; g < SECTORS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fix_vld[g] <= 1'b0;
                fix_off[g] <= '0;
                fix_bit[g] <= '0;
            end else if (clear_i) begin
                fix_vld[g] <= 1'b0;
            end else if (set_i && (set_sec_i == SEC_W'(g))) begin
                fix_vld[g] <= 1'b1;
                fix_off[g] <= set_off_i;
                fix_bit[g] <= set_bit_i;
            end
        end
        assign hit[g] = fix_vld[g] && (p_sec == SEC_W'(g)) && (fix_off[g] == p_off);
    end

    always_comb begin
        patch_out_o = patch_in_i;
        for (int s = 0; s < SECTORS; s++) begin
            if (hit[s]) begin
                patch_out_o = patch_in_i ^ (8'd1 << fix_bit[s]);
            end
        end
    end

endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
    import nand_ecc_pkg::*;
#(
    parameter int SECTORS = 4,
    localparam int SEC_W  = $clog2(SECTORS),
    localparam int ADDR_W = SEC_W + LOC_OFF_W,
    localparam int BUS_W  = SECTORS * CODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 multi,
    input  logic [BUS_W-1:0]     stored_code,
    input  logic [BUS_W-1:0]     calc_code,
    output logic                 busy,
    output logic                 res_valid,
    output logic [1:0]           res_status,
    output logic [SEC_W-1:0]     res_sector,
    output logic [LOC_OFF_W-1:0] res_offset,
    output logic [LOC_BIT_W-1:0] res_bit,
    output logic                 res_last,
    input  logic [ADDR_W-1:0]    patch_addr,
    input  logic [7:0]           patch_in,
    output logic [7:0]           patch_out
);

    scan_state_e          state, nxt;
    logic [SEC_W-1:0]     idx;
    logic                 multi_q;
    logic [BUS_W-1:0]     stored_q, calc_q;
    ecc_status_e          cur_status;
    logic [LOC_OFF_W-1:0] cur_off;
    logic [LOC_BIT_W-1:0] cur_bit;
    logic                 sect_last, go, stop;

    assign go        = (state == S_IDLE) && start;
    assign sect_last = multi_q ? (idx == SEC_W'(SECTORS-1)) : (idx == '0);
    assign stop      = sect_last || (cur_status == ST_FATAL);
    assign busy      = (state == S_SCAN);

    ecc_syndrome_unit u_syn (
        .stored_i (stored_q[idx*CODE_W +: CODE_W]),
        .calc_i   (calc_q[idx*CODE_W +: CODE_W]),
        .status_o (cur_status),
        .off_o    (cur_off),
        .bit_o    (cur_bit)
    );

    ecc_fix_store #(.SECTORS(SECTORS)) u_fix (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (go),
        .set_i        (busy && (cur_status == ST_FIXED)),
        .set_sec_i    (idx),
        .set_off_i    (cur_off),
        .set_bit_i    (cur_bit),
        .patch_addr_i (patch_addr),
        .patch_in_i   (patch_in),
        .patch_out_o  (patch_out)
    );

    // Transitions: GO (S_IDLE->S_SCAN), NEXT (S_SCAN->S_SCAN), STOP (S_SCAN->S_IDLE)
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_SCAN;
            S_SCAN: if (stop)  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            idx      <= '0;
            multi_q  <= 1'b0;
            stored_q <= '0;
            calc_q   <= '0;
        end else begin
            state <= nxt;
            if (go) begin
                idx      <= '0;
                multi_q  <= multi;
                stored_q <= stored_code;
                calc_q   <= calc_code;
            end else if (busy) begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_status <= 2'b00;
            res_sector <= '0;
            res_offset <= '0;
            res_bit    <= '0;
            res_last   <= 1'b0;
        end else if (busy) begin
            res_valid  <= 1'b1;
            res_status <= cur_status;
            res_sector <= idx;
            res_offset <= cur_off;
            res_bit    <= cur_bit;
            res_last   <= stop;
        end else begin
            res_valid  <= 1'b0;
            res_status <= 2'b00;
            res_sector <= '0;
            res_offset <= '0;
            res_bit    <= '0;
            res_last   <= 1'b0;
        end
    end

endmodule

// File: rtl/nand_ecc_checker.sv
module nand_ecc_checker #(
    parameter int SEC_W = 2,
    parameter int OFF_W = 9,
    parameter int BIT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             res_valid,
    input logic [1:0]       res_status,
    input logic [SEC_W-1:0] res_sector,
    input logic [OFF_W-1:0] res_offset,
    input logic [BIT_W-1:0] res_bit,
    input logic             res_last
);

    AST_CLEAN_NO_LOC: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (res_status == 2'b00) |-> (res_offset == '0) && (res_bit == '0)); // R1

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_status != 2'b11)); // R4

    AST_SECTOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_last |=> res_valid && (res_sector == $past(res_sector) + 1'b1)); // R5

    AST_FATAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (res_status == 2'b10) |-> res_last); // R6

    AST_LAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_last |=> !res_valid); // R6

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy); // R9

    AST_FIRST_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> res_valid && (res_sector == '0)); // R9

endmodule

bind nand_ecc_corrector nand_ecc_checker #(
    .SEC_W (SEC_W),
    .OFF_W (nand_ecc_pkg::LOC_OFF_W),
    .BIT_W (nand_ecc_pkg::LOC_BIT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .res_valid  (res_valid),
    .res_status (res_status),
    .res_sector (res_sector),
    .res_offset (res_offset),
    .res_bit    (res_bit),
    .res_last   (res_last)
);

// File: tb/tb_nand_ecc_corrector.sv
module tb_nand_ecc_corrector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        multi = 1'b0;
    logic [95:0] stored_code = '0;
    logic [95:0] calc_code = '0;
    logic        busy, res_valid, res_last;
    logic [1:0]  res_status, res_sector;
    logic [8:0]  res_offset;
    logic [2:0]  res_bit;
    logic [10:0] patch_addr = '0;
    logic [7:0]  patch_in = '0;
    logic [7:0]  patch_out;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 0;

    logic [1:0] g_st [4];
    logic [1:0] g_sec [4];
    logic [8:0] g_off [4];
    logic [2:0] g_bit [4];
    int         g_n;

    always #4 clk = ~clk;

    nand_ecc_corrector dut (
        .clk(clk), .rst_n(rst_n), .start(start), .multi(multi),
        .stored_code(stored_code), .calc_code(calc_code),
        .busy(busy), .res_valid(res_valid), .res_status(res_status),
        .res_sector(res_sector), .res_offset(res_offset), .res_bit(res_bit),
        .res_last(res_last), .patch_addr(patch_addr), .patch_in(patch_in),
        .patch_out(patch_out)
    );

    // {data_mode, exp_status, stored, arg}; data_mode: arg[11:0] = {offset, bit}
    localparam logic [50:0] VEC [11] = '{
        {1'b0, 2'b00, 24'h5A3C96, 24'h000000},
        {1'b1, 2'b01, 24'h123456, 24'h000000},
        {1'b1, 2'b01, 24'hABCDEF, 24'h000FFF},
        {1'b1, 2'b01, 24'h0F0F0F, 24'h0002A5},
        {1'b0, 2'b10, 24'hC3C3C3, 24'h000100},
        {1'b0, 2'b10, 24'h00FF00, 24'h0007FF},
        {1'b0, 2'b00, 24'hFFFFFF, 24'hFFFFFF},
        {1'b0, 2'b10, 24'h000000, 24'hFFFFFF},
        {1'b1, 2'b01, 24'hFFFFFF, 24'h000801},
        {1'b0, 2'b10, 24'h777777, 24'h000003},
        {1'b0, 2'b10, 24'h13579B, 24'h001FFF}
    };

    function automatic logic [23:0] data_mask(input logic [11:0] a);
        logic [23:0] m;
        m = '0;
        for (int k = 0; k < 12; k++) begin
            if (a[k]) m[(k < 8) ? (8 + k) : (12 + k)] = 1'b1;
            else      m[(k < 8) ? k : (8 + k)] = 1'b1;
        end
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_page(input logic m, input logic [95:0] s, input logic [95:0] c,
                            input bit poke);
        g_n = 0;
        @(negedge clk);
        start = 1'b1; multi = m; stored_code = s; calc_code = c;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "busy after start", 32'(busy), 1);
        @(negedge clk);
        check(res_valid == 1'b1, "R9", "first result latency", 32'(res_valid), 1);
        for (int i = 0; i < 6; i++) begin
            if (!res_valid || g_n == 4) break;
            g_st[g_n]  = res_status;
            g_sec[g_n] = res_sector;
            g_off[g_n] = res_offset;
            g_bit[g_n] = res_bit;
            g_n++;
            if (res_last) break;
            if (poke && g_n == 1) begin
                start = 1'b1; calc_code = s; multi = 1'b0;
            end
            @(negedge clk);
            start = 1'b0;
        end
        @(negedge clk);
        check(!res_valid && !busy, "R6", "quiet after last result",
              32'({res_valid, busy}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        patch_addr = 11'h203; patch_in = 8'hA5;
        #1;
        check(!res_valid && !busy, "R10", "outputs in reset", 32'({res_valid, busy}), 0);
        check(patch_out == 8'hA5, "R10", "patch passthrough", 32'(patch_out), 32'h A5);
        rst_n = 1'b1;
        @(negedge clk);
        check(!res_valid && !busy, "R10", "idle after reset", 32'({res_valid, busy}), 0);

        // Vector table, single-sector mode; upper slices deliberately mismatched (R7)
        for (int v = 0; v < 11; v++) begin
            logic [23:0] sv, cv;
            logic [1:0]  ex;
            string       tag;
            sv = VEC[v][47:24];
            ex = VEC[v][49:48];
            cv = VEC[v][50] ? (sv ^ data_mask(VEC[v][11:0])) : (sv ^ VEC[v][23:0]);
            tag = (ex == 2'b01) ? "R2" : (ex == 2'b00) ? ((VEC[v][23:0] == 0) ? "R1" : "R4")
                : ((v == 4 || v == 5) ? "R3" : "R4");
            run_page(1'b0, {72'h123456789ABCDEF012, sv}, {72'h0, cv}, 1'b0);
            check(g_n == 1, "R7", "single-sector result count", 32'(g_n), 1);
            check(g_st[0] == ex, tag, "status", 32'(g_st[0]), 32'(ex));
            if (ex == 2'b01) begin
                check(g_off[0] == VEC[v][11:3], "R2", "offset", 32'(g_off[0]), 32'(VEC[v][11:3]));
                check(g_bit[0] == VEC[v][2:0], "R2", "bit", 32'(g_bit[0]), 32'(VEC[v][2:0]));
            end else if (ex == 2'b00) begin
                check({g_off[0], g_bit[0]} == 12'h0, "R1", "clean location",
                      32'({g_off[0], g_bit[0]}), 0);
            end
        end

        // R5 / R8: four sectors, corrections in sectors 1 and 3
        run_page(1'b1,
                 {24'h444444, 24'h333333, 24'h222222, 24'h111111},
                 {24'h444444 ^ data_mask({9'd511, 3'd0}), 24'h333333,
                  24'h222222 ^ data_mask({9'd3, 3'd4}), 24'h111111}, 1'b0);
        check(g_n == 4, "R5", "four results", 32'(g_n), 4);
        for (int i = 0; i < 4; i++) begin
            check(g_sec[i] == 2'(i), "R5", "sector order", 32'(g_sec[i]), 32'(i));
            check(g_st[i] == ((i % 2) ? 2'b01 : 2'b00), "R5", "sector status",
                  32'(g_st[i]), 32'((i % 2) ? 1 : 0));
        end
        check(g_off[1] == 9'd3 && g_bit[1] == 3'd4, "R5", "sector 1 location",
              32'({g_off[1], g_bit[1]}), 32'({9'd3, 3'd4}));
        check(g_off[3] == 9'd511 && g_bit[3] == 3'd0, "R5", "sector 3 location",
              32'({g_off[3], g_bit[3]}), 32'({9'd511, 3'd0}));
        patch_addr = {2'd1, 9'd3}; patch_in = 8'h00; #1;
        check(patch_out == 8'h10, "R8", "patch sector 1", 32'(patch_out), 32'h10);
        patch_addr = {2'd3, 9'd511}; patch_in = 8'hFF; #1;
        check(patch_out == 8'hFE, "R8", "patch sector 3", 32'(patch_out), 32'hFE);
        patch_addr = {2'd1, 9'd4}; patch_in = 8'h5A; #1;
        check(patch_out == 8'h5A, "R8", "neighbour byte untouched", 32'(patch_out), 32'h5A);
        patch_addr = {2'd0, 9'd3}; #1;
        check(patch_out == 8'h5A, "R8", "other sector untouched", 32'(patch_out), 32'h5A);

        // R6: abort at sector 1; R8: previous corrections cleared
        run_page(1'b1,
                 {24'h0, 24'h0, 24'h555555, 24'hAAAAAA},
                 {24'h0, 24'h0, 24'h555555 ^ 24'h000100,
                  24'hAAAAAA ^ data_mask({9'd7, 3'd2})}, 1'b0);
        check(g_n == 2, "R6", "abort result count", 32'(g_n), 2);
        check(g_st[1] == 2'b10, "R6", "abort status", 32'(g_st[1]), 2);
        patch_addr = {2'd1, 9'd3}; patch_in = 8'h00; #1;
        check(patch_out == 8'h00, "R8", "cleared by new start", 32'(patch_out), 0);
        patch_addr = {2'd0, 9'd7}; #1;
        check(patch_out == 8'h04, "R8", "patch sector 0", 32'(patch_out), 32'h04);

        // R9: start and input changes while busy are ignored
        run_page(1'b1,
                 {24'h0A0A0A, 24'h0B0B0B, 24'h0C0C0C, 24'h0D0D0D},
                 {24'h0A0A0A, 24'h0B0B0B ^ data_mask({9'd100, 3'd6}), 24'h0C0C0C, 24'h0D0D0D},
                 1'b1);
        check(g_n == 4, "R9", "run unaffected by restart", 32'(g_n), 4);
        check(g_st[2] == 2'b01 && g_off[2] == 9'd100 && g_bit[2] == 3'd6, "R9",
              "latched codes used", 32'({g_st[2], g_off[2], g_bit[2]}),
              32'({2'b01, 9'd100, 3'd6}));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule